// File: doc/BRIEF.md
# Register Rename Map with Free List

This block sits at the dispatch point of an out-of-order core and translates architectural register numbers into physical register tags, one instruction per cycle, in program order. It keeps a speculative map from every architectural register to the physical register holding its newest value, and a pool of physical registers that no instruction currently owns. Each renamed instruction has its two sources looked up through the speculative map. If it writes a register, it receives a fresh physical tag together with the tag that destination held before. The caller carries that old tag down the pipeline, because it may only be released once the superseding write has committed.

A second copy of the map holds only committed state. A commit port records a retiring write in that copy and returns the superseded physical register to the pool. A flush input discards all speculation: the speculative map is reloaded from the committed copy, and every physical register handed out since the last commit goes back to the pool. Rename requests use a valid/ready handshake. The block lowers ready while the pool is empty or a flush is being taken, and it holds no state for a request it did not accept, so the sender keeps its request steady until ready is high. The commit and flush pins are plain control inputs without back-pressure.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and physical registers NUM_ARCH to NUM_PHYS-1 are free.
- R2: `ren_src0_tag` and `ren_src1_tag` give the current speculative mapping of `ren_src0` and `ren_src1`. An instruction that reads its own destination sees the mapping that was in place before its own allocation.
- R3: On an accepted request with `ren_dst_en` = 1, `ren_new_tag` is the lowest-numbered free physical register. From the next cycle it is the mapping of `ren_dst` and is no longer free.
- R4: `ren_old_tag` gives the mapping that `ren_dst` held before the request, and it differs from `ren_new_tag`.
- R5: An accepted request with `ren_dst_en` = 0 allocates nothing and leaves the map unchanged.
- R6: `ren_ready` is 0 while no physical register is free. A request offered while `ren_ready` is 0 changes neither the map nor the pool.
- R7: A commit (`cmt_valid` = 1) records `cmt_arch` -> `cmt_new_tag` in the committed map and returns `cmt_old_tag` to the pool from the next cycle.
- R8: A flush (`flush` = 1) holds `ren_ready` at 0 for that cycle. From the next cycle the speculative map equals the committed map, including a commit taken in the same cycle, and every uncommitted physical register is free, which leaves NUM_PHYS-NUM_ARCH free.
- R9: A rename and a commit in the same cycle both take effect. The register released by the commit is not offered to the rename in that cycle, but it is available from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request valid |
| ren_ready | output | 1 | Block can accept a rename this cycle |
| ren_dst_en | input | 1 | Request writes a destination |
| ren_dst | input | $clog2(NUM_ARCH) | Architectural destination |
| ren_src0 | input | $clog2(NUM_ARCH) | Architectural source 0 |
| ren_src1 | input | $clog2(NUM_ARCH) | Architectural source 1 |
| ren_src0_tag | output | $clog2(NUM_PHYS) | Physical tag of source 0 |
| ren_src1_tag | output | $clog2(NUM_PHYS) | Physical tag of source 1 |
| ren_new_tag | output | $clog2(NUM_PHYS) | Physical register allocated to the destination |
| ren_old_tag | output | $clog2(NUM_PHYS) | Previous mapping of the destination |
| cmt_valid | input | 1 | A register-writing instruction retires |
| cmt_arch | input | $clog2(NUM_ARCH) | Its architectural destination |
| cmt_new_tag | input | $clog2(NUM_PHYS) | Its allocated physical register |
| cmt_old_tag | input | $clog2(NUM_PHYS) | Physical register it superseded, to be freed |
| flush | input | 1 | Discard speculative state |

## Verification
Two pairs of functions can share a cycle: a rename that takes a register can coincide with a commit that releases one, and a commit can coincide with a flush. The bench renames a destination in the same cycle as a commit of a different register. It checks that the rename gets the lowest register that was already free, and that in the next cycle the released register is the one offered. It also commits a write in the flush cycle itself, then checks through the source lookup that the reloaded map contains that commit and, through the next offered tag, that the committed register stayed allocated while the others were returned to the pool.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned DEF_NUM_ARCH = 32;
  localparam int unsigned DEF_NUM_PHYS = 64;

  // Request to change one map entry
  typedef struct packed {
    logic       en;
    logic [7:0] arch;
    logic [7:0] tag;
  } map_wr_t;
endpackage

// File: rtl/rename_freelist.sv
module rename_freelist
  import rename_pkg::*;
#(
  parameter int unsigned NUM_ARCH = DEF_NUM_ARCH,
  parameter int unsigned NUM_PHYS = DEF_NUM_PHYS,
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_en,
  output logic [TW-1:0]       alloc_tag,
  output logic                any_free,
  input  logic                rel_en,
  input  logic [TW-1:0]       rel_tag,
  input  logic [TW-1:0]       keep_tag,
  input  logic                flush,
  output logic [NUM_PHYS-1:0] free_vec
);
  logic [NUM_PHYS-1:0] free_q, free_d;
  logic [NUM_PHYS-1:0] held_q, held_d;   // owned by committed state
  logic [NUM_PHYS-1:0] take_oh, rel_oh, keep_oh;

  // lowest-numbered free register wins
  always_comb begin
    alloc_tag = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_tag = TW'(i);
    end
  end

  assign any_free = |free_q;

  always_comb begin
    take_oh = '0;
    rel_oh  = '0;
    keep_oh = '0;
    if (alloc_en) take_oh[alloc_tag] = 1'b1;
    if (rel_en) begin
      rel_oh[rel_tag]   = 1'b1;
      keep_oh[keep_tag] = 1'b1;
    end
  end

  always_comb begin
    held_d = (held_q & ~rel_oh) | keep_oh;
    if (flush) free_d = ~held_d;
    else       free_d = (free_q & ~take_oh) | rel_oh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) begin
        held_q[i] <= (i < NUM_ARCH);
        free_q[i] <= (i >= NUM_ARCH);
      end
    end else begin
      held_q <= held_d;
      free_q <= free_d;
    end
  end

  assign free_vec = free_q;
endmodule

// File: rtl/rename_map.sv
module rename_map
  import rename_pkg::*;
#(
  parameter int unsigned NUM_ARCH = DEF_NUM_ARCH,
  parameter int unsigned NUM_PHYS = DEF_NUM_PHYS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd0_arch,
  output logic [TW-1:0] rd0_tag,
  input  logic [AW-1:0] rd1_arch,
  output logic [TW-1:0] rd1_tag,
  input  logic [AW-1:0] rdd_arch,
  output logic [TW-1:0] rdd_tag,
  input  map_wr_t       spec_wr,
  input  map_wr_t       cmt_wr,
  input  logic          flush
);
  logic [TW-1:0] spec_q [NUM_ARCH];
  logic [TW-1:0] cmt_q  [NUM_ARCH];
  logic [TW-1:0] cmt_d  [NUM_ARCH];

  assign rd0_tag = spec_q[rd0_arch];
  assign rd1_tag = spec_q[rd1_arch];
  assign rdd_tag = spec_q[rdd_arch];

  generate
    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_entry
      logic cmt_hit, spec_hit;
      assign cmt_hit  = cmt_wr.en  && (cmt_wr.arch  == 8'(g));
      assign spec_hit = spec_wr.en && (spec_wr.arch == 8'(g));
      assign cmt_d[g] = cmt_hit ? cmt_wr.tag[TW-1:0] : cmt_q[g];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cmt_q[g]  <= TW'(g);
          spec_q[g] <= TW'(g);
        end else begin
          cmt_q[g] <= cmt_d[g];
          if (flush)         spec_q[g] <= cmt_d[g];
          else if (spec_hit) spec_q[g] <= spec_wr.tag[TW-1:0];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/reg_rename.sv
module reg_rename
  import rename_pkg::*;
#(
  parameter int unsigned NUM_ARCH = DEF_NUM_ARCH,
  parameter int unsigned NUM_PHYS = DEF_NUM_PHYS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic          ren_dst_en,
  input  logic [AW-1:0] ren_dst,
  input  logic [AW-1:0] ren_src0,
  input  logic [AW-1:0] ren_src1,
  output logic [TW-1:0] ren_src0_tag,
  output logic [TW-1:0] ren_src1_tag,
  output logic [TW-1:0] ren_new_tag,
  output logic [TW-1:0] ren_old_tag,
  input  logic          cmt_valid,
  input  logic [AW-1:0] cmt_arch,
  input  logic [TW-1:0] cmt_new_tag,
  input  logic [TW-1:0] cmt_old_tag,
  input  logic          flush
);
  logic                any_free;
  logic                alloc;
  logic [NUM_PHYS-1:0] free_vec;
  map_wr_t             spec_wr, cmt_wr;

  assign ren_ready = any_free && !flush;
  assign alloc     = ren_valid && ren_ready && ren_dst_en;

  always_comb begin
    spec_wr      = '0;
    spec_wr.en   = alloc;
    spec_wr.arch = 8'(ren_dst);
    spec_wr.tag  = 8'(ren_new_tag);
    cmt_wr       = '0;
    cmt_wr.en    = cmt_valid;
    cmt_wr.arch  = 8'(cmt_arch);
    cmt_wr.tag   = 8'(cmt_new_tag);
  end

  rename_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd0_arch (ren_src0),
    .rd0_tag  (ren_src0_tag),
    .rd1_arch (ren_src1),
    .rd1_tag  (ren_src1_tag),
    .rdd_arch (ren_dst),
    .rdd_tag  (ren_old_tag),
    .spec_wr  (spec_wr),
    .cmt_wr   (cmt_wr),
    .flush    (flush)
  );

  rename_freelist #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc),
    .alloc_tag (ren_new_tag),
    .any_free  (any_free),
    .rel_en    (cmt_valid),
    .rel_tag   (cmt_old_tag),
    .keep_tag  (cmt_new_tag),
    .flush     (flush),
    .free_vec  (free_vec)
  );
endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned NUM_PHYS = 64,
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ren_valid,
  input logic                ren_ready,
  input logic                ren_dst_en,
  input logic [TW-1:0]       ren_new_tag,
  input logic [TW-1:0]       ren_old_tag,
  input logic                cmt_valid,
  input logic [TW-1:0]       cmt_old_tag,
  input logic                flush,
  input logic [NUM_PHYS-1:0] free_vec
);
  logic take;
  assign take = ren_valid && ren_ready && ren_dst_en;

  // R6
  p_stall_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (free_vec == '0) |-> !ren_ready);

  // R3
  p_new_was_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> free_vec[ren_new_tag]);

  p_new_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !free_vec[$past(ren_new_tag)]);

  // R4
  p_old_differs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ren_new_tag != ren_old_tag));

  // R7
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> free_vec[$past(cmt_old_tag)]);

  // R8
  p_flush_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !ren_ready);

  p_flush_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(free_vec) == (NUM_PHYS - NUM_ARCH)));
endmodule

bind reg_rename reg_rename_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ren_valid   (ren_valid),
  .ren_ready   (ren_ready),
  .ren_dst_en  (ren_dst_en),
  .ren_new_tag (ren_new_tag),
  .ren_old_tag (ren_old_tag),
  .cmt_valid   (cmt_valid),
  .cmt_old_tag (cmt_old_tag),
  .flush       (flush),
  .free_vec    (free_vec)
);

// File: tb/tb_reg_rename.sv
module tb_reg_rename;
  localparam int NA = 32;
  localparam int NP = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ren_valid, ren_ready, ren_dst_en;
  logic [4:0] ren_dst, ren_src0, ren_src1;
  logic [5:0] ren_src0_tag, ren_src1_tag, ren_new_tag, ren_old_tag;
  logic       cmt_valid;
  logic [4:0] cmt_arch;
  logic [5:0] cmt_new_tag, cmt_old_tag;
  logic       flush;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  reg_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP)) dut (.*);

  // fields: dst_en, dst, s0, s1, exp_s0, exp_s1, exp_new, exp_old
  localparam logic [39:0] TBL [6] = '{
    {1'b1, 5'd3, 5'd1, 5'd2, 6'd1,  6'd2,  6'd32, 6'd3 },
    {1'b1, 5'd4, 5'd3, 5'd1, 6'd32, 6'd1,  6'd33, 6'd4 },
    {1'b1, 5'd3, 5'd4, 5'd2, 6'd33, 6'd2,  6'd34, 6'd32},
    {1'b0, 5'd7, 5'd3, 5'd4, 6'd34, 6'd33, 6'd0,  6'd0 },
    {1'b1, 5'd5, 5'd5, 5'd5, 6'd5,  6'd5,  6'd35, 6'd5 },
    {1'b1, 5'd3, 5'd3, 5'd0, 6'd34, 6'd0,  6'd36, 6'd34}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ren_valid = 0; ren_dst_en = 0; ren_dst = 0; ren_src0 = 0; ren_src1 = 0;
    cmt_valid = 0; cmt_arch = 0; cmt_new_tag = 0; cmt_old_tag = 0; flush = 0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: identity map and first free register
    ren_src0 = 5'd31; ren_src1 = 5'd9; #2;
    chk("R1 src0 map", ren_src0_tag, 31);
    chk("R1 src1 map", ren_src1_tag, 9);
    chk("R1 first free", ren_new_tag, 32);
    chk("R1 ready", ren_ready, 1);
    @(negedge clk);

    // R2 R3 R4 R5: table walk
    for (int k = 0; k < 6; k++) begin
      ren_valid = 1;
      ren_dst_en = TBL[k][39];
      ren_dst    = TBL[k][38:34];
      ren_src0   = TBL[k][33:29];
      ren_src1   = TBL[k][28:24];
      #2;
      chk("R2 src0", ren_src0_tag, int'(TBL[k][23:18]));
      chk("R2 src1", ren_src1_tag, int'(TBL[k][17:12]));
      if (TBL[k][39]) begin
        chk("R3 new tag", ren_new_tag, int'(TBL[k][11:6]));
        chk("R4 old tag", ren_old_tag, int'(TBL[k][5:0]));
      end
      nxt();
    end
    idle();

    // R7: commit R3 (32 over 3) frees 3
    cmt_valid = 1; cmt_arch = 3; cmt_new_tag = 32; cmt_old_tag = 3;
    nxt(); idle(); #2;
    chk("R7 released reg offered", ren_new_tag, 3);
    @(negedge clk);

    // R9: rename R6 while committing R4 (33 over 4)
    ren_valid = 1; ren_dst_en = 1; ren_dst = 6; ren_src0 = 6;
    cmt_valid = 1; cmt_arch = 4; cmt_new_tag = 33; cmt_old_tag = 4;
    #2;
    chk("R9 rename gets prior free", ren_new_tag, 3);
    chk("R9 old tag", ren_old_tag, 6);
    nxt(); idle(); #2;
    chk("R9 released next cycle", ren_new_tag, 4);
    ren_src0 = 6; #1;
    chk("R9 rename took effect", ren_src0_tag, 3);
    @(negedge clk);

    // R8: flush restores committed map
    flush = 1; ren_valid = 1; ren_dst_en = 1; ren_dst = 9; #2;
    chk("R8 ready low in flush", ren_ready, 0);
    nxt(); idle();
    ren_src0 = 3; ren_src1 = 4; #2;
    chk("R8 committed R3", ren_src0_tag, 32);
    chk("R8 committed R4", ren_src1_tag, 33);
    ren_src0 = 6; ren_src1 = 5; #1;
    chk("R8 R6 restored", ren_src0_tag, 6);
    chk("R8 R5 restored", ren_src1_tag, 5);
    chk("R8 uncommitted freed", ren_new_tag, 3);
    ren_src0 = 9; #1;
    chk("R6 R8 no rename during flush", ren_src0_tag, 9);
    @(negedge clk);

    // R8: commit in the flush cycle
    ren_valid = 1; ren_dst_en = 1; ren_dst = 7; ren_src0 = 7; #2;
    chk("R2 self read old map", ren_src0_tag, 7);
    chk("R3 alloc", ren_new_tag, 3);
    nxt(); idle();
    flush = 1; cmt_valid = 1; cmt_arch = 7; cmt_new_tag = 3; cmt_old_tag = 7;
    nxt(); idle();
    ren_src0 = 7; #2;
    chk("R8 same-cycle commit kept", ren_src0_tag, 3);
    chk("R8 lowest free after", ren_new_tag, 4);
    @(negedge clk);

    // R6: drain the pool (32 free)
    for (int k = 0; k < NP - NA; k++) begin
      ren_valid = 1; ren_dst_en = 1; ren_dst = 1; #2;
      if (!ren_ready) chk("R6 ready while free", ren_ready, 1);
      nxt();
    end
    idle(); #2;
    chk("R6 empty stalls", ren_ready, 0);
    @(negedge clk);
    ren_valid = 1; ren_dst_en = 1; ren_dst = 2;
    nxt(); idle();
    ren_src0 = 2; #2;
    chk("R6 stalled request ignored", ren_src0_tag, 2);
    chk("R6 still empty", ren_ready, 0);
    @(negedge clk);
    cmt_valid = 1; cmt_arch = 1; cmt_new_tag = 4; cmt_old_tag = 1;
    nxt(); idle(); #2;
    chk("R7 ready after release", ren_ready, 1);
    chk("R7 released reg", ren_new_tag, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule